// File: doc/BRIEF.md
# Sync-Point Triple-Lane Voter

This block sits beside three redundant processing lanes that execute the same instruction stream. It does not compare them on every clock. Each lane reports taken branches and interrupt boundaries. A lane reaches a synchronisation point either at an interrupt boundary or when it has counted a programmable number N of taken branches since the last vote. At that moment the block captures the lane's state signature. When every enabled lane has reached the point, the three captured signatures are compared. A lane that disagrees with the other two is locked out until reset, and the majority value is presented as the voted signature.

The lanes may reach a synchronisation point at different cycles, because each lane's signature is captured at its own arrival. A timeout bounds how long the block waits for a lagging lane. When it expires, the lanes that have not arrived are treated as failed and locked out. A two-lane mode uses lanes 0 and 1 only. In that mode a mismatch can be detected but not corrected, so it raises the no-majority alarm.

Top module: `tmr_sync_voter`

## Requirements
- R1: After reset `lane_en_o` is 3'b111, or 3'b011 when `dual_mode_i` is 1. `lane_fault_o`, `no_major_o`, `voted_vld_o`, `sync_o` and `voted_sig_o` are all zero.
- R2: An enabled lane reaches its sync point on the taken-branch pulse that brings its count since the last vote to N, where N is `period_i` and a value of 0 counts as 1. Its signature is captured in that same cycle, and earlier pulses cause no vote.
- R3: An interrupt-boundary pulse makes an enabled lane arrive at once, whatever its branch count. After every vote, all branch counts restart from zero.
- R4: Once every enabled lane has arrived, a vote is taken. `sync_o` is high for one cycle, and the vote results appear on the outputs two clock edges after the last arrival pulse.
- R5: If all participating signatures agree, `voted_sig_o` takes that value and `voted_vld_o` is 1. The enable mask and the fault flags are unchanged.
- R6: If exactly one of three participating lanes differs from two that agree, `voted_sig_o` takes the agreed value and the dissenting lane's bit in `lane_fault_o` is set. That lane's bit in `lane_en_o` clears and stays clear, and the lane's later pulses are ignored.
- R7: If three participating signatures all differ, `no_major_o` is set, `voted_vld_o` is 0, `voted_sig_o` holds its previous value and no lane is locked out.
- R8: If two participating lanes disagree, `no_major_o` is set and `voted_vld_o` is 0. Both flags keep those values until reset, although a later agreeing vote still updates `voted_sig_o`.
- R9: In two-lane mode (`dual_mode_i` = 1), lane 2 is disabled and its inputs are ignored. A mismatch between lanes 0 and 1 raises `no_major_o` and locks out no lane.
- R10: If some enabled lane has arrived and the others have not arrived within TIMEOUT cycles, the vote is taken among the arrived lanes. The missing lanes get their fault bits set and are locked out.
- R11: Reset clears partial branch counts, lockouts, faults and the alarm.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| dual_mode_i | input | 1 | 1 selects two-lane detect-only mode |
| period_i | input | CNT_W | Taken branches per sync point (0 acts as 1) |
| lane_sig_i | input | 3 x SIG_W | State signature of each lane |
| lane_br_i | input | 3 | Per-lane taken-branch pulse |
| lane_irq_i | input | 3 | Per-lane interrupt-boundary pulse |
| voted_sig_o | output | SIG_W | Voted signature |
| voted_vld_o | output | 1 | Voted signature is trustworthy |
| lane_en_o | output | 3 | Lanes still taking part |
| lane_fault_o | output | 3 | Lanes locked out for a fault |
| no_major_o | output | 1 | Sticky no-majority alarm |
| sync_o | output | 1 | One-cycle pulse when a vote is taken |

## Verification
The assertions take for granted that a lane that has arrived sends no further branch or interrupt pulse until the vote clears it. They also assume that `period_i` and `dual_mode_i` change only while reset is held. The stimulus meets this by driving every pulse for exactly one cycle, and it changes mode and period only around reset. It also starts the next event only after the previous vote has fired. Lane skew in the stimulus stays a few cycles below TIMEOUT, except in the one case that exercises the timeout on purpose.

// File: rtl/tmr_sync_pkg.sv
package tmr_sync_pkg;
    localparam int LANES = 3;
    typedef logic [LANES-1:0] lane_mask_t;
endpackage

// File: rtl/tmr_lane_track.sv
module tmr_lane_track #(
    parameter int SIG_W = 16,
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             active_i,
    input  logic             clear_i,
    input  logic [CNT_W-1:0] period_i,
    input  logic             br_i,
    input  logic             irq_i,
    input  logic [SIG_W-1:0] sig_i,
    output logic             arrived_o,
    output logic [SIG_W-1:0] cap_o
);
    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic             arr;
        logic [SIG_W-1:0] cap;
    } trk_t;

    trk_t s_d, s_q;
    logic [CNT_W-1:0] last_c;

    assign last_c = (period_i == '0) ? '0 : period_i - 1'b1;

    always_comb begin
        s_d = s_q;
        if (clear_i || !active_i) begin
            s_d.cnt = '0;
            s_d.arr = 1'b0;
        end else if (!s_q.arr) begin
            if (irq_i || (br_i && s_q.cnt == last_c)) begin
                s_d.arr = 1'b1;
                s_d.cap = sig_i;
                s_d.cnt = '0;
            end else if (br_i) begin
                s_d.cnt = s_q.cnt + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign arrived_o = s_q.arr;
    assign cap_o     = s_q.cap;

    assert_arrival_held_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.arr && !clear_i && active_i) |=> s_q.arr);

    assert_capture_stable_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.arr && !clear_i) |=> $stable(s_q.cap));
endmodule

// File: rtl/tmr_vote_core.sv
module tmr_vote_core #(
    parameter int SIG_W = 16
) (
    input  logic [2:0]            part_i,
    input  logic [2:0][SIG_W-1:0] cap_i,
    output logic                  agree_o,
    output logic                  nomaj_o,
    output logic [2:0]            dissent_o,
    output logic [SIG_W-1:0]      voted_o
);
    logic eq01, eq02, eq12;

    assign eq01 = (cap_i[0] == cap_i[1]);
    assign eq02 = (cap_i[0] == cap_i[2]);
    assign eq12 = (cap_i[1] == cap_i[2]);

    always_comb begin
        agree_o   = 1'b0;
        nomaj_o   = 1'b0;
        dissent_o = 3'b000;
        voted_o   = cap_i[0];
        case (part_i)
            3'b111: begin
                if (eq01 && eq02) begin
                    agree_o = 1'b1;
                end else if (eq01) begin
                    agree_o   = 1'b1;
                    dissent_o = 3'b100;
                end else if (eq02) begin
                    agree_o   = 1'b1;
                    dissent_o = 3'b010;
                end else if (eq12) begin
                    agree_o   = 1'b1;
                    dissent_o = 3'b001;
                    voted_o   = cap_i[1];
                end else begin
                    nomaj_o = 1'b1;
                end
            end
            3'b011: begin agree_o = eq01; nomaj_o = !eq01; end
            3'b101: begin agree_o = eq02; nomaj_o = !eq02; end
            3'b110: begin agree_o = eq12; nomaj_o = !eq12; voted_o = cap_i[1]; end
            default: nomaj_o = 1'b1;
        endcase
    end
endmodule

// File: rtl/tmr_sync_voter.sv
module tmr_sync_voter
    import tmr_sync_pkg::*;
#(
    parameter int SIG_W   = 16,
    parameter int CNT_W   = 8,
    parameter int TIMEOUT = 16
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      dual_mode_i,
    input  logic [CNT_W-1:0]          period_i,
    input  logic [LANES-1:0][SIG_W-1:0] lane_sig_i,
    input  logic [LANES-1:0]          lane_br_i,
    input  logic [LANES-1:0]          lane_irq_i,
    output logic [SIG_W-1:0]          voted_sig_o,
    output logic                      voted_vld_o,
    output logic [LANES-1:0]          lane_en_o,
    output logic [LANES-1:0]          lane_fault_o,
    output logic                      no_major_o,
    output logic                      sync_o
);
    localparam int TMR_W = $clog2(TIMEOUT + 1);

    typedef struct packed {
        lane_mask_t       en;
        lane_mask_t       fault;
        logic             nomaj;
        logic             vld;
        logic [SIG_W-1:0] voted;
        logic             sync;
        logic [TMR_W-1:0] tmr;
    } vst_t;

    vst_t s_d, s_q;

    lane_mask_t                   mask, act, arr, part, missing;
    logic [LANES-1:0][SIG_W-1:0]  cap;
    logic                         all_in, waiting, tmo, fire;
    logic                         v_agree, v_nomaj;
    lane_mask_t                   v_dissent;
    logic [SIG_W-1:0]             v_sig;

    assign mask    = dual_mode_i ? 3'b011 : 3'b111;
    assign act     = s_q.en & mask;
    assign part    = arr & act;
    assign all_in  = (act != '0) && (part == act);
    assign waiting = (part != '0) && !all_in;
    assign tmo     = waiting && (s_q.tmr == TMR_W'(TIMEOUT - 1));
    assign fire    = all_in || tmo;
    assign missing = tmo ? (act & ~part) : '0;

    for (genvar i = 0; i < LANES; i++) begin : g_lane
        tmr_lane_track #(.SIG_W(SIG_W), .CNT_W(CNT_W)) u_trk (
            .clk       (clk),
            .rst_n     (rst_n),
            .active_i  (act[i]),
            .clear_i   (fire),
            .period_i  (period_i),
            .br_i      (lane_br_i[i]),
            .irq_i     (lane_irq_i[i]),
            .sig_i     (lane_sig_i[i]),
            .arrived_o (arr[i]),
            .cap_o     (cap[i])
        );
    end

    tmr_vote_core #(.SIG_W(SIG_W)) u_core (
        .part_i    (part),
        .cap_i     (cap),
        .agree_o   (v_agree),
        .nomaj_o   (v_nomaj),
        .dissent_o (v_dissent),
        .voted_o   (v_sig)
    );

    always_comb begin
        s_d      = s_q;
        s_d.sync = 1'b0;
        s_d.tmr  = (waiting && !fire) ? s_q.tmr + 1'b1 : '0;
        if (fire) begin
            s_d.sync  = 1'b1;
            s_d.en    = s_q.en & ~(v_dissent | missing);
            s_d.fault = s_q.fault | v_dissent | missing;
            if (v_nomaj) begin
                s_d.nomaj = 1'b1;
                s_d.vld   = 1'b0;
            end else if (v_agree) begin
                s_d.voted = v_sig;
                s_d.vld   = !s_q.nomaj;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q    <= '0;
            s_q.en <= '1;
        end else begin
            s_q <= s_d;
        end
    end

    assign voted_sig_o  = s_q.voted;
    assign voted_vld_o  = s_q.vld;
    assign lane_en_o    = act;
    assign lane_fault_o = s_q.fault;
    assign no_major_o   = s_q.nomaj;
    assign sync_o       = s_q.sync;

    assert_lockout_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.en & ~$past(s_q.en)) == '0);

    assert_fault_locked_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.fault & s_q.en) == '0);

    assert_enable_change_on_sync_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.en != $past(s_q.en)) |-> s_q.sync);

    assert_alarm_invalid_R8: assert property (@(posedge clk) disable iff (!rst_n)
        s_q.nomaj |-> !s_q.vld);

    assert_alarm_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
        s_q.nomaj |=> s_q.nomaj);

    assert_valid_rise_on_sync_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(s_q.vld) |-> s_q.sync);

    assert_timer_bound_R10: assert property (@(posedge clk) disable iff (!rst_n)
        s_q.tmr < TMR_W'(TIMEOUT));
endmodule

// File: tb/tmr_sync_voter_bench.sv
module tmr_sync_voter_bench;
    localparam int SIG_W = 16;
    localparam int CNT_W = 8;
    localparam int TMO   = 16;

    logic                    clk = 1'b0;
    logic                    rst_n = 1'b0;
    logic                    dual_mode_i = 1'b0;
    logic [CNT_W-1:0]        period_i = 8'd3;
    logic [2:0][SIG_W-1:0]   lane_sig_i = '0;
    logic [2:0]              lane_br_i = '0;
    logic [2:0]              lane_irq_i = '0;
    logic [SIG_W-1:0]        voted_sig_o;
    logic                    voted_vld_o;
    logic [2:0]              lane_en_o;
    logic [2:0]              lane_fault_o;
    logic                    no_major_o;
    logic                    sync_o;

    int tests = 0;
    int fails = 0;
    bit done  = 1'b0;

    typedef struct {
        logic [SIG_W-1:0] sig;
        logic             vld;
        logic [2:0]       en;
        logic [2:0]       flt;
        logic             nm;
        string            req;
    } exp_t;
    exp_t exp_q[$];

    always #2.5 clk = ~clk;

    tmr_sync_voter #(.SIG_W(SIG_W), .CNT_W(CNT_W), .TIMEOUT(TMO)) u_tmr_sync_voter (
        .clk(clk), .rst_n(rst_n), .dual_mode_i(dual_mode_i), .period_i(period_i),
        .lane_sig_i(lane_sig_i), .lane_br_i(lane_br_i), .lane_irq_i(lane_irq_i),
        .voted_sig_o(voted_sig_o), .voted_vld_o(voted_vld_o), .lane_en_o(lane_en_o),
        .lane_fault_o(lane_fault_o), .no_major_o(no_major_o), .sync_o(sync_o)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
        end
    endtask

    task automatic expect_vote(input logic [SIG_W-1:0] sig, input logic vld,
                               input logic [2:0] en, input logic [2:0] flt,
                               input logic nm, input string req);
        exp_t e;
        e.sig = sig; e.vld = vld; e.en = en; e.flt = flt; e.nm = nm; e.req = req;
        exp_q.push_back(e);
    endtask

    task automatic drive(input logic [2:0] br, input logic [2:0] irq,
                         input logic [SIG_W-1:0] s0, input logic [SIG_W-1:0] s1,
                         input logic [SIG_W-1:0] s2, input bit timing);
        @(negedge clk);
        lane_sig_i[0] = s0; lane_sig_i[1] = s1; lane_sig_i[2] = s2;
        lane_br_i = br; lane_irq_i = irq;
        @(negedge clk);
        lane_br_i = '0; lane_irq_i = '0;
        if (timing) begin
            @(negedge clk);
            chk(sync_o == 1'b1, "R4", "sync two edges after last arrival", sync_o, 1);
        end
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic do_reset(input bit dual);
        @(negedge clk);
        rst_n = 1'b0; dual_mode_i = dual; lane_br_i = '0; lane_irq_i = '0;
        idle(3);
        rst_n = 1'b1;
    endtask

    task automatic check_reset(input logic [2:0] en_exp, input string req);
        chk(lane_en_o == en_exp, req, "reset lane_en", lane_en_o, en_exp);
        chk(lane_fault_o == 3'b000 && no_major_o == 1'b0, req, "reset flags",
            {lane_fault_o, no_major_o}, 0);
        chk(voted_vld_o == 1'b0 && voted_sig_o == '0 && sync_o == 1'b0, req,
            "reset vote outputs", {voted_vld_o, voted_sig_o, sync_o}, 0);
    endtask

    // Monitor: every vote pulse pops the next expected result
    initial begin
        forever begin
            @(negedge clk);
            if (rst_n && sync_o) begin
                if (exp_q.size() == 0) begin
                    chk(1'b0, "R2", "vote with none expected", 1, 0);
                end else begin
                    exp_t e;
                    e = exp_q.pop_front();
                    chk(voted_sig_o == e.sig, e.req, "voted_sig", voted_sig_o, e.sig);
                    chk(voted_vld_o == e.vld, e.req, "voted_vld", voted_vld_o, e.vld);
                    chk(lane_en_o == e.en, e.req, "lane_en", lane_en_o, e.en);
                    chk(lane_fault_o == e.flt, e.req, "lane_fault", lane_fault_o, e.flt);
                    chk(no_major_o == e.nm, e.req, "no_major", no_major_o, e.nm);
                end
            end
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            tests++; fails++;
            $display("FAIL watchdog: run did not finish");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        period_i = 8'd3;
        do_reset(1'b0);
        check_reset(3'b111, "R1");

        // R2: two branches do not reach the sync point, the third does
        drive(3'b111, 3'b000, 16'h1111, 16'h1111, 16'h1111, 1'b0);
        drive(3'b111, 3'b000, 16'h1111, 16'h1111, 16'h1111, 1'b0);
        idle(4);
        expect_vote(16'hA0A0, 1'b1, 3'b111, 3'b000, 1'b0, "R2 R5");
        drive(3'b111, 3'b000, 16'hA0A0, 16'hA0A0, 16'hA0A0, 1'b1);

        // R3: interrupt boundary arrives mid-count, then count restarts
        drive(3'b111, 3'b000, 16'h2222, 16'h2222, 16'h2222, 1'b0);
        expect_vote(16'hB0B0, 1'b1, 3'b111, 3'b000, 1'b0, "R3");
        drive(3'b000, 3'b111, 16'hB0B0, 16'hB0B0, 16'hB0B0, 1'b1);
        drive(3'b111, 3'b000, 16'h3333, 16'h3333, 16'h3333, 1'b0);
        drive(3'b111, 3'b000, 16'h3333, 16'h3333, 16'h3333, 1'b0);
        idle(4);
        expect_vote(16'hC0C0, 1'b1, 3'b111, 3'b000, 1'b0, "R3");
        drive(3'b111, 3'b000, 16'hC0C0, 16'hC0C0, 16'hC0C0, 1'b1);

        // R4 R2: skewed arrival, signature captured at each lane's own pulse
        drive(3'b111, 3'b000, 16'h4444, 16'h4444, 16'h4444, 1'b0);
        drive(3'b111, 3'b000, 16'h4444, 16'h4444, 16'h4444, 1'b0);
        drive(3'b001, 3'b000, 16'hD0D0, 16'h4444, 16'h4444, 1'b0);
        drive(3'b000, 3'b000, 16'hEEEE, 16'h4444, 16'h4444, 1'b0);
        drive(3'b010, 3'b000, 16'hEEEE, 16'hD0D0, 16'h4444, 1'b0);
        expect_vote(16'hD0D0, 1'b1, 3'b111, 3'b000, 1'b0, "R4");
        drive(3'b100, 3'b000, 16'hEEEE, 16'h5555, 16'hD0D0, 1'b1);

        // R6: lane 1 dissents and is locked out
        expect_vote(16'hE0E0, 1'b1, 3'b101, 3'b010, 1'b0, "R6");
        drive(3'b000, 3'b111, 16'hE0E0, 16'h0BAD, 16'hE0E0, 1'b1);
        // R6: lane 1 alone pulsing causes no vote, and its signature is ignored
        drive(3'b000, 3'b010, 16'h0, 16'h0BAD, 16'h0, 1'b0);
        idle(5);
        chk(lane_en_o == 3'b101, "R6", "locked lane stays off", lane_en_o, 3'b101);
        expect_vote(16'hF0F0, 1'b1, 3'b101, 3'b010, 1'b0, "R6");
        drive(3'b000, 3'b111, 16'hF0F0, 16'h1BAD, 16'hF0F0, 1'b1);

        // R8: two remaining lanes disagree, alarm is sticky
        expect_vote(16'hF0F0, 1'b0, 3'b101, 3'b010, 1'b1, "R8");
        drive(3'b000, 3'b101, 16'h1234, 16'h0, 16'h5678, 1'b1);
        expect_vote(16'h9090, 1'b0, 3'b101, 3'b010, 1'b1, "R8");
        drive(3'b000, 3'b101, 16'h9090, 16'h0, 16'h9090, 1'b1);

        // R11: partial count and all flags cleared by reset
        drive(3'b101, 3'b000, 16'h0, 16'h0, 16'h0, 1'b0);
        do_reset(1'b0);
        check_reset(3'b111, "R11");
        drive(3'b111, 3'b000, 16'h0, 16'h0, 16'h0, 1'b0);
        drive(3'b111, 3'b000, 16'h0, 16'h0, 16'h0, 1'b0);
        idle(4);
        expect_vote(16'h7070, 1'b1, 3'b111, 3'b000, 1'b0, "R11");
        drive(3'b111, 3'b000, 16'h7070, 16'h7070, 16'h7070, 1'b1);

        // R7: all three differ
        expect_vote(16'h7070, 1'b0, 3'b111, 3'b000, 1'b1, "R7");
        drive(3'b000, 3'b111, 16'h0001, 16'h0002, 16'h0003, 1'b1);

        // R10: lane 2 never arrives
        do_reset(1'b0);
        expect_vote(16'h6060, 1'b1, 3'b011, 3'b100, 1'b0, "R10");
        drive(3'b000, 3'b011, 16'h6060, 16'h6060, 16'h0, 1'b0);
        idle(TMO + 6);
        chk(exp_q.size() == 0, "R10", "timeout vote taken", exp_q.size(), 0);

        // R9: two-lane mode
        do_reset(1'b1);
        check_reset(3'b011, "R9");
        expect_vote(16'h5050, 1'b1, 3'b011, 3'b000, 1'b0, "R9");
        drive(3'b000, 3'b111, 16'h5050, 16'h5050, 16'hDEAD, 1'b1);
        expect_vote(16'h5050, 1'b0, 3'b011, 3'b000, 1'b1, "R9");
        drive(3'b000, 3'b011, 16'h0101, 16'h0202, 16'h0, 1'b1);

        idle(5);
        chk(exp_q.size() == 0, "R4", "all expected votes taken", exp_q.size(), 0);
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule